// File: doc/BRIEF.md
# Parallel-Port Key Responder

This block acts as a copy-protection key sitting on a parallel-port data and status pair. Every byte written to the data port goes into a four-stage unlock detector. The detector runs on every write, whatever state the block is in. When the unlock sequence completes, the block collects a fifteen-byte password. It keeps only bytes whose least significant bit is set. It compares the password with a fixed key as the bytes arrive, and the result selects one of two response sets.

After the password, one further write arms the block. From then on, each written byte is a query. The query either raises one bit of the status byte or leaves the status at zero. Status reads return the current status byte one cycle after the request.

The write path is a valid/ready stream. `wr_ready` is held high, so the block never applies back-pressure, and a write is taken on every clock edge where `wr_valid` is high. The read path has no back-pressure either. `rd_valid` pulses one cycle after `rd_req`, and `rd_data` carries the status byte sampled at that request edge.

Top module: `dngl_resp`

## Requirements
- R1: After reset the status byte is 0x00, the block is idle, and neither response set is armed.
- R2: `wr_ready` is always 1. A cycle with `rd_req` high makes `rd_valid` high in the next cycle, and `rd_data` then holds the status byte as it stood at the request edge.
- R3: The block enters password capture with index 0 only when the bytes 0xC6, 0xC7, 0xC6 and 0x80 arrive as four consecutive writes. A byte that breaks the sequence sends the detector back to its first stage, and that byte is not re-examined as a new first byte.
- R4: In capture, only written bytes with bit 0 set are stored. Bytes with bit 0 clear do not advance the index. The fifteenth stored byte ends capture.
- R5: If the stored bytes equal C3 D9 D3 FB 9D 89 B9 A1 B3 C1 F1 CD DF 9D 9D in arrival order, response set 1 is chosen; otherwise set 0 is chosen.
- R6: The first write after capture ends arms query mode and yields status 0x00 whatever its value.
- R7: Every write clears the status byte to 0x00 before any response is applied. Status only ever reads 0x00 or 0x20 (bit 5).
- R8: In set 1, queries 0x8A, 0x8E, 0xCA, 0xD2, 0xE2, 0xF0 and 0xFC give 0x20. Queries 0x94, 0x9E, 0xA4, 0xB2, 0xBE and 0xD0 give 0x00.
- R9: In both sets, queries 0x88, 0x98, 0x9C, 0xA0, 0xAA, 0xAE, 0xB0, 0xBC, 0xC2, 0xC6, 0xC8, 0xCE, 0xD6, 0xD8, 0xDC, 0xE0, 0xE6, 0xEA, 0xEE, 0xF2 and 0xF6 give 0x20. In set 0, queries 0x94, 0x9E, 0xA4, 0xB2, 0xBE and 0xD0 also give 0x20. Any other query gives 0x00.
- R10: If the sequence breaks at its third byte (0xC6 expected, something else written), the block returns to idle, even from query mode.
- R11: The detector runs during capture and query. A complete unlock sequence restarts capture at index 0 and discards any partial password.
- R12: Outside query mode, every write leaves the status byte at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Data-port write strobe |
| wr_ready | output | 1 | Always 1; no back-pressure |
| wr_data | input | 8 | Written data byte |
| rd_req | input | 1 | Status-port read strobe |
| rd_valid | output | 1 | Read data valid, one cycle after rd_req |
| rd_data | output | 8 | Status byte |

## Verification
A detector stage that is wrong shows up in one of two ways. Either a query reads 0x00 where 0x20 was due, because the block fell back to idle, or a password is never captured. The first read after the next query exposes it. A wrong capture index or a faulty bit-0 filter shifts the end of capture by one or more writes. The arming write then lands on a real query, or a query lands on the arming write, so the mismatch appears within one or two writes of the password. A wrong response-set flag shows only on the thirteen query bytes that differ between the sets, so the query table mixes those bytes with common and silent ones in both sets.

// File: rtl/dngl_pkg.sv
package dngl_pkg;

  localparam int PW_LEN = 15;
  localparam int RESP_BIT = 5;
  localparam logic [PW_LEN*8-1:0] PW_KEY = 120'hC3D9D3FB9D89B9A1B3C1F1CDDF9D9D;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_CAPTURE = 2'd1,
    PH_PASSEND = 2'd2,
    PH_QUERY   = 2'd3
  } phase_t;

  function automatic logic [7:0] key_byte(input int idx);
    return PW_KEY[(PW_LEN-1-idx)*8 +: 8];
  endfunction

  // queries answered with the flag under either response set
  function automatic logic hit_common(input logic [7:0] q);
    case (q)
      8'h88, 8'h98, 8'h9C, 8'hA0, 8'hAA, 8'hAE, 8'hB0,
      8'hBC, 8'hC2, 8'hC6, 8'hC8, 8'hCE, 8'hD6, 8'hD8,
      8'hDC, 8'hE0, 8'hE6, 8'hEA, 8'hEE, 8'hF2, 8'hF6: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // queries the matched set answers with the flag on top of the common ones
  function automatic logic hit_set1_extra(input logic [7:0] q);
    case (q)
      8'h8A, 8'h8E, 8'hCA, 8'hD2, 8'hE2, 8'hF0, 8'hFC: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // queries silenced by the matched set but flagged by the unmatched set
  function automatic logic hit_set0_only(input logic [7:0] q);
    case (q)
      8'h94, 8'h9E, 8'hA4, 8'hB2, 8'hBE, 8'hD0: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dngl_unlock.sv
module dngl_unlock #(
  parameter int SEQ_LEN = 4,
  parameter logic [SEQ_LEN*8-1:0] SEQ = 32'hC6C7C680,
  parameter int ABORT_AT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_fire,
  input  logic [7:0] wr_data,
  output logic       seq_done,
  output logic       seq_abort
);
  localparam int SW = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam logic [SW-1:0] LAST_STAGE = SW'(SEQ_LEN-1);
  localparam logic [SW-1:0] ABORT_STAGE = SW'(ABORT_AT);

  logic [SW-1:0] stage_q;
  logic [7:0]    want;
  logic          is_match, is_last;

  always_comb begin
    want     = SEQ[(SEQ_LEN-1-int'(stage_q))*8 +: 8];
    is_match = (wr_data == want);
    is_last  = (stage_q == LAST_STAGE);
  end

  assign seq_done  = wr_fire && is_last && is_match;
  assign seq_abort = wr_fire && (stage_q == ABORT_STAGE) && !is_match;

  always_ff @(posedge clk) begin
    if (!rst_n)
      stage_q <= '0;
    else if (wr_fire)
      stage_q <= (is_match && !is_last) ? stage_q + 1'b1 : '0;
  end
endmodule

// File: rtl/dngl_capture.sv
module dngl_capture
  import dngl_pkg::*;
#(
  parameter int LEN = PW_LEN
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   restart,
  input  logic                   take,
  input  logic [7:0]             byte_in,
  output logic                   cap_done,
  output logic                   cap_match,
  output logic [$clog2(LEN)-1:0] cap_idx
);
  localparam int IW = $clog2(LEN);
  localparam logic [IW-1:0] LAST_IDX = IW'(LEN-1);

  logic [IW-1:0] idx_q;
  logic          same_q;
  logic          byte_ok;

  assign byte_ok   = (byte_in == key_byte(int'(idx_q)));
  assign cap_done  = take && (idx_q == LAST_IDX);
  assign cap_match = same_q && byte_ok;
  assign cap_idx   = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      same_q <= 1'b1;
    end else if (restart) begin
      idx_q  <= '0;
      same_q <= 1'b1;
    end else if (take) begin
      idx_q  <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      same_q <= same_q && byte_ok;
    end
  end
endmodule

// File: rtl/dngl_answer.sv
module dngl_answer
  import dngl_pkg::*;
#(
  parameter int FLAG_BIT = RESP_BIT
) (
  input  logic [7:0] query,
  input  logic       set1,
  output logic [7:0] reply
);
  logic hit;

  always_comb begin
    if (set1)
      hit = hit_common(query) || hit_set1_extra(query);
    else
      hit = hit_common(query) || hit_set0_only(query);
    reply = hit ? (8'h01 << FLAG_BIT) : 8'h00;
  end
endmodule

// File: rtl/dngl_resp.sv
module dngl_resp
  import dngl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data,
  input  logic       rd_req,
  output logic       rd_valid,
  output logic [7:0] rd_data
);
  localparam int IW = $clog2(PW_LEN);

  phase_t        phase_q, eff_phase, phase_d;
  logic          set1_q;
  logic [7:0]    status_q;
  logic          wr_fire;
  logic          seq_done, seq_abort;
  logic          take, cap_done, cap_match;
  logic [IW-1:0] cap_idx;
  logic [7:0]    reply;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid;

  dngl_unlock #(.SEQ_LEN(4), .SEQ(32'hC6C7C680), .ABORT_AT(2)) u_unlock (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_data(wr_data),
    .seq_done(seq_done), .seq_abort(seq_abort)
  );

  // phase as seen by the current write, after the detector has acted
  always_comb begin
    if (seq_done)       eff_phase = PH_CAPTURE;
    else if (seq_abort) eff_phase = PH_IDLE;
    else                eff_phase = phase_q;
  end

  assign take = wr_fire && (eff_phase == PH_CAPTURE) && wr_data[0];

  dngl_capture #(.LEN(PW_LEN)) u_capture (
    .clk(clk), .rst_n(rst_n), .restart(seq_done), .take(take),
    .byte_in(wr_data), .cap_done(cap_done), .cap_match(cap_match),
    .cap_idx(cap_idx)
  );

  dngl_answer #(.FLAG_BIT(RESP_BIT)) u_answer (
    .query(wr_data), .set1(set1_q), .reply(reply)
  );

  always_comb begin
    case (eff_phase)
      PH_CAPTURE: phase_d = cap_done ? PH_PASSEND : PH_CAPTURE;
      PH_PASSEND: phase_d = PH_QUERY;
      PH_QUERY:   phase_d = PH_QUERY;
      default:    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      set1_q   <= 1'b0;
      status_q <= 8'h00;
    end else if (wr_fire) begin
      phase_q  <= phase_d;
      status_q <= (eff_phase == PH_QUERY) ? reply : 8'h00;
      if (cap_done) set1_q <= cap_match;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= status_q;
    end
  end
endmodule

// File: rtl/dngl_resp_chk.sv
module dngl_resp_chk
  import dngl_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_valid,
  input logic                      wr_ready,
  input logic [7:0]                wr_data,
  input logic                      rd_req,
  input logic                      rd_valid,
  input logic [7:0]                rd_data,
  input phase_t                    phase_q,
  input logic [7:0]                status_q,
  input logic [$clog2(PW_LEN)-1:0] cap_idx
);
  // R2
  rd_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (rd_valid && rd_data == $past(status_q)));
  // R2
  wr_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);
  // R12
  quiet_outside_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q != 8'h00) |-> (phase_q == PH_QUERY));
  // R7
  status_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == 8'h00) || (status_q == 8'h20));
  // R3
  capture_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CAPTURE && $past(phase_q) != PH_CAPTURE) |->
      ($past(wr_valid) && $past(wr_data) == 8'h80 && cap_idx == '0));
  // R4
  capture_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PASSEND && $past(phase_q) == PH_CAPTURE) |->
      ($past(wr_valid) && $past(wr_data[0])));
  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cap_idx) < PW_LEN);
  // R6
  arm_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_q) == PH_PASSEND && phase_q == PH_QUERY) |-> (status_q == 8'h00));
  // R10
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(phase_q));
endmodule

bind dngl_resp dngl_resp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_data(wr_data), .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
  .phase_q(phase_q), .status_q(status_q), .cap_idx(cap_idx)
);

// File: tb/dngl_resp_tb.sv
`timescale 1ns/1ps
module dngl_resp_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = 8'h00;
  logic       rd_req = 1'b0;
  logic       rd_valid;
  logic [7:0] rd_data;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  dngl_resp u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // {query, expected with matched password, expected with other password}
  localparam logic [23:0] QTAB [14] = '{
    24'h88_20_20, 24'h94_00_20, 24'h8A_20_00, 24'h9E_00_20, 24'hCA_20_00,
    24'hF6_20_20, 24'h00_00_00, 24'h96_00_00, 24'hFC_20_00, 24'hD0_00_20,
    24'hC2_20_20, 24'h89_00_00, 24'hE2_20_00, 24'hDC_20_20
  };
  localparam logic [119:0] GOOD_PW = 120'hC3D9D3FB9D89B9A1B3C1F1CDDF9D9D;
  localparam logic [119:0] BAD_PW  = 120'hC3D9D3FB9D89B9A1B3C1F1CDDF9D9F;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_valid = 1'b1; wr_data = b;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] exp);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    chk({req, " rd_valid"}, {7'd0, rd_valid}, 8'h01);
    chk(req, rd_data, exp);
  endtask

  task automatic unlock();
    wr(8'hC6); wr(8'hC7); wr(8'hC6); wr(8'h80);
  endtask

  task automatic send_pw(input logic [119:0] pw, input int n);
    for (int i = 0; i < n; i++) wr(pw[(14-i)*8 +: 8]);
  endtask

  task automatic walk_table(input bit set1, input string req);
    for (int i = 0; i < 14; i++) begin
      wr(QTAB[i][23:16]);
      rd_chk(req, set1 ? QTAB[i][15:8] : QTAB[i][7:0]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R2 ready
    rd_chk("R1", 8'h00);
    chk("R2 wr_ready", {7'd0, wr_ready}, 8'h01);
    // R12 idle writes stay silent
    wr(8'h88); rd_chk("R12", 8'h00);
    // R3 broken sequence: C6 C6 C7 C6 80 must not unlock
    wr(8'hC6); wr(8'hC6); wr(8'hC7); wr(8'hC6); wr(8'h80);
    send_pw(GOOD_PW, 15); wr(8'h88); wr(8'h88);
    rd_chk("R3", 8'h00);
    // R4 capture with even filler bytes interleaved
    unlock();
    for (int i = 0; i < 14; i++) begin
      wr(GOOD_PW[(14-i)*8 +: 8]);
      if (i % 3 == 0) wr(8'h42);
    end
    rd_chk("R12 capture", 8'h00);
    wr(GOOD_PW[7:0]);
    // R6 arming write silent even for a flagged byte
    wr(8'h88); rd_chk("R6", 8'h00);
    wr(8'h88); rd_chk("R4 R6 query live", 8'h20);
    // R5 R8 R9 R7 matched set
    walk_table(1'b1, "R8 R5");
    wr(8'hF6); wr(8'h00); rd_chk("R7", 8'h00);
    // R11 re-unlock from query mode with wrong password
    wr(8'hC6); rd_chk("R11 C6 answered", 8'h20);
    wr(8'hC7); wr(8'hC6); wr(8'h80);
    send_pw(BAD_PW, 15); wr(8'h11);
    walk_table(1'b0, "R9 R5");
    // R10 third-byte break returns to idle
    wr(8'hC6); wr(8'hC7); wr(8'h00);
    wr(8'h88); rd_chk("R10", 8'h00);
    // R11 restart mid-capture discards partial password
    unlock(); send_pw(BAD_PW, 5);
    unlock(); send_pw(GOOD_PW, 15); wr(8'h11);
    wr(8'h8A); rd_chk("R11 restart", 8'h20);
    // R1 reset from query mode
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_chk("R1 rereset", 8'h00);
    wr(8'h88); rd_chk("R1 idle after reset", 8'h00);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule